// File: doc/BRIEF.md
# Load Result Formatter

This block sits between a data memory and a register file. It takes the raw little-endian bytes that memory returns for a load and shapes them into the value written to the destination register or register pair. It handles five operation kinds. A plain load takes a byte, half, word or double and may extend it. Two expansion loads spread bytes across 16-bit lanes. Two alignment loads shift the old destination pair right and push the new bytes in at the top.

A load may also be made conditional on a predicate. When the condition fails, the block issues no memory read. It writes zero to the destination and raises a cancel flag.

Control is a four-state machine:
- `ST_IDLE` waits for a request.
- `ST_FETCH` holds the memory read request until data arrives.
- `ST_DONE` presents the formatted result for one cycle.
- `ST_CANCEL` presents the zero result of a suppressed load for one cycle.

The transitions are:
- accept: `ST_IDLE` to `ST_FETCH`, on a request whose condition holds.
- suppress: `ST_IDLE` to `ST_CANCEL`, on a request whose condition fails.
- capture: `ST_FETCH` to `ST_DONE`, on data valid.
- retire: `ST_DONE` to `ST_IDLE`.
- drop: `ST_CANCEL` to `ST_IDLE`.

Top module: `ldfmt_top`

## Requirements
- R1: After reset, `mem_rd`, `res_we` and `cancel` are low and `res_data` is zero.
- R2: A request seen in idle whose condition holds (or that is not predicated) raises `mem_rd` on the next cycle. `mem_rd` stays high until a cycle in which `mem_valid` is sampled high.
- R3: The result appears on `res_data`, with `res_we` high, in the cycle after the clock edge that samples `mem_valid` high during a fetch. `res_we` lasts exactly one cycle, after which the block is idle again and `res_data` holds its value.
- R4: Plain load (op 0) reads from the low bytes of `mem_data` by size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. For 1 and 2 bytes, `sign_ext` = 1 sign-extends to 64 bits and 0 zero-extends. For 4 bytes, bits 63:32 are zero. 8 bytes are passed whole.
- R5: Two-lane expansion (op 1) puts byte k of `mem_data` (k = 0, 1) into bits 16k+15:16k, each byte extended to 16 bits per `sign_ext`. Bits 63:32 are zero.
- R6: Four-lane expansion (op 2) puts byte k of `mem_data` (k = 0..3) into bits 16k+15:16k, each extended to 16 bits per `sign_ext`.
- R7: Half alignment (op 3) gives `{mem_data[15:0], old_pair[63:16]}`, where `old_pair` is the value sampled with the request.
- R8: Byte alignment (op 4) gives `{mem_data[7:0], old_pair[63:8]}`, with `old_pair` sampled with the request.
- R9: With `pred_en` high, the condition is bit 0 of `pred_new` when `pred_sel[1]` = 1, or bit 0 of `pred_old` when it is 0. The condition is inverted when `pred_sel[0]` = 1. Predicate bits above bit 0 have no effect.
- R10: A request whose condition fails never raises `mem_rd`. On the next cycle `res_we` and `cancel` are high and `res_data` is zero, and the block then returns to idle.
- R11: `req_valid` is ignored outside idle, and its fields do not disturb the load in progress. `mem_valid` is ignored outside a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| op | input | 3 | Operation: 0 plain, 1 two-lane expand, 2 four-lane expand, 3 half align, 4 byte align |
| size | input | 2 | Plain-load size code |
| sign_ext | input | 1 | 1 = sign extension, 0 = zero extension |
| pred_en | input | 1 | Load is conditional |
| pred_sel | input | 2 | bit 1: use new predicate; bit 0: invert |
| pred_old | input | 8 | Committed predicate value |
| pred_new | input | 8 | Predicate produced in the same packet |
| old_pair | input | 64 | Current destination pair value |
| mem_valid | input | 1 | Memory data valid |
| mem_data | input | 64 | Raw little-endian memory data |
| mem_rd | output | 1 | Memory read request |
| res_we | output | 1 | Destination write enable |
| cancel | output | 1 | The load was suppressed by its predicate |
| res_data | output | 64 | Formatted result |

## Verification
Plain loads are tried with bytes whose top bit is set and with bytes whose top bit is clear. Running each under both extension settings separates sign extension from zero extension, and separates it from wrongly sized fields. The expansion patterns use a distinct value in every byte, with mixed top bits, so that a swapped lane or a lane extended with the wrong rule shows up. The alignment loads run on an old pair of distinct bytes, and the pair is changed during the fetch, which shows whether the right shift and the sampling point are right. Predicated loads step through all four selector codes with the condition both true and false, with junk in the upper predicate bits. Fetches of varying wait length are run with stray requests and stray data-valid pulses.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN  = 3'd0,
        OP_EXP2   = 3'd1,
        OP_EXP4   = 3'd2,
        OP_ALIGNH = 3'd3,
        OP_ALIGNB = 3'd4
    } ld_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DONE,
        ST_CANCEL
    } ld_state_e;

    typedef struct packed {
        ld_op_e   op;
        ld_size_e size;
        logic     sign;
    } ld_cmd_t;

endpackage

// File: rtl/ldfmt_pred.sv
module ldfmt_pred #(
    parameter int PRED_W = 8
) (
    input  logic              pred_en,
    input  logic [1:0]        pred_sel,
    input  logic [PRED_W-1:0] pred_old,
    input  logic [PRED_W-1:0] pred_new,
    output logic              go
);
    logic picked;
    logic unused_hi;

    // only the least significant predicate bit carries the condition
    assign unused_hi = ^{pred_old[PRED_W-1:1], pred_new[PRED_W-1:1]};

    always_comb begin
        picked = pred_sel[1] ? pred_new[0] : pred_old[0];
        go     = !pred_en || (picked ^ pred_sel[0]);
    end
endmodule

// File: rtl/ldfmt_shape.sv
module ldfmt_shape
    import ldfmt_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  ld_cmd_t                cmd,
    input  logic [8*LANE_W-1:0]    raw,
    output logic [8*LANE_W-1:0]    shaped
);
    localparam int PAIR_W = 8 * LANE_W;
    localparam int HALF_W = 2 * LANE_W;
    localparam int WORD_W = 4 * LANE_W;
    localparam int N_EXP  = 4;

    logic [HALF_W-1:0] lane_ext [N_EXP];
    logic [PAIR_W-1:0] plain;
    logic [PAIR_W-1:0] exp2;
    logic [PAIR_W-1:0] exp4;

    // each of the low four bytes widened to a half-word lane
    for (genvar g = 0; g < N_EXP; g++) begin : g_lane
        logic top_bit;
        assign top_bit     = cmd.sign & raw[g*LANE_W + LANE_W - 1];
        assign lane_ext[g] = {{LANE_W{top_bit}}, raw[g*LANE_W +: LANE_W]};
    end

    always_comb begin
        unique case (cmd.size)
            SZ_BYTE: plain = {{(PAIR_W-LANE_W){cmd.sign & raw[LANE_W-1]}}, raw[LANE_W-1:0]};
            SZ_HALF: plain = {{(PAIR_W-HALF_W){cmd.sign & raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            SZ_WORD: plain = {{(PAIR_W-WORD_W){1'b0}}, raw[WORD_W-1:0]};
            SZ_DBL:  plain = raw;
            default: plain = raw;
        endcase
    end

    assign exp2 = {{(PAIR_W-2*HALF_W){1'b0}}, lane_ext[1], lane_ext[0]};
    assign exp4 = {lane_ext[3], lane_ext[2], lane_ext[1], lane_ext[0]};

    always_comb begin
        unique case (cmd.op)
            OP_EXP2: shaped = exp2;
            OP_EXP4: shaped = exp4;
            default: shaped = plain;
        endcase
    end
endmodule

// File: rtl/ldfmt_align.sv
module ldfmt_align #(
    parameter int LANE_W = 8
) (
    input  logic                       half_mode,
    input  logic [2*LANE_W-1:0]        raw_lo,
    input  logic [8*LANE_W-1:LANE_W]   old_hi,
    output logic [8*LANE_W-1:0]        merged
);
    localparam int PAIR_W = 8 * LANE_W;
    localparam int HALF_W = 2 * LANE_W;

    always_comb begin
        if (half_mode)
            merged = {raw_lo, old_hi[PAIR_W-1:HALF_W]};
        else
            merged = {raw_lo[LANE_W-1:0], old_hi[PAIR_W-1:LANE_W]};
    end
endmodule

// File: rtl/ldfmt_ctrl.sv
module ldfmt_ctrl
    import ldfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic pred_go,
    input  logic mem_valid,
    output logic mem_rd,
    output logic cmd_load,
    output logic res_capture,
    output logic res_clear,
    output logic res_we,
    output logic cancel
);
    ld_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = pred_go ? ST_FETCH : ST_CANCEL;
            ST_FETCH:  if (mem_valid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_CANCEL: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_rd      = (state_q == ST_FETCH);
        res_we      = (state_q == ST_DONE) || (state_q == ST_CANCEL);
        cancel      = (state_q == ST_CANCEL);
        cmd_load    = (state_q == ST_IDLE) && req_valid && pred_go;
        res_clear   = (state_q == ST_IDLE) && req_valid && !pred_go;
        res_capture = (state_q == ST_FETCH) && mem_valid;
    end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
    import ldfmt_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int PRED_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [2:0]             op,
    input  logic [1:0]             size,
    input  logic                   sign_ext,
    input  logic                   pred_en,
    input  logic [1:0]             pred_sel,
    input  logic [PRED_W-1:0]      pred_old,
    input  logic [PRED_W-1:0]      pred_new,
    input  logic [8*LANE_W-1:0]    old_pair,
    input  logic                   mem_valid,
    input  logic [8*LANE_W-1:0]    mem_data,
    output logic                   mem_rd,
    output logic                   res_we,
    output logic                   cancel,
    output logic [8*LANE_W-1:0]    res_data
);
    localparam int PAIR_W = 8 * LANE_W;
    localparam int HALF_W = 2 * LANE_W;

    logic                     pred_go;
    logic                     cmd_load, res_capture, res_clear;
    ld_cmd_t                  cmd_q;
    logic [PAIR_W-1:LANE_W]   old_q;
    logic [PAIR_W-1:0]        shaped, merged, formatted, res_q;
    logic                     unused_old_lo;

    assign unused_old_lo = ^old_pair[LANE_W-1:0];

    ldfmt_pred #(.PRED_W(PRED_W)) u_pred (
        .pred_en  (pred_en),
        .pred_sel (pred_sel),
        .pred_old (pred_old),
        .pred_new (pred_new),
        .go       (pred_go)
    );

    ldfmt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .pred_go     (pred_go),
        .mem_valid   (mem_valid),
        .mem_rd      (mem_rd),
        .cmd_load    (cmd_load),
        .res_capture (res_capture),
        .res_clear   (res_clear),
        .res_we      (res_we),
        .cancel      (cancel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '{op: OP_PLAIN, size: SZ_BYTE, sign: 1'b0};
            old_q <= '0;
        end else if (cmd_load) begin
            cmd_q <= '{op: ld_op_e'(op), size: ld_size_e'(size), sign: sign_ext};
            old_q <= old_pair[PAIR_W-1:LANE_W];
        end
    end

    ldfmt_shape #(.LANE_W(LANE_W)) u_shape (
        .cmd    (cmd_q),
        .raw    (mem_data),
        .shaped (shaped)
    );

    ldfmt_align #(.LANE_W(LANE_W)) u_align (
        .half_mode (cmd_q.op == OP_ALIGNH),
        .raw_lo    (mem_data[HALF_W-1:0]),
        .old_hi    (old_q),
        .merged    (merged)
    );

    assign formatted = (cmd_q.op == OP_ALIGNH || cmd_q.op == OP_ALIGNB) ? merged : shaped;

    always_ff @(posedge clk) begin
        if (!rst_n)           res_q <= '0;
        else if (res_clear)   res_q <= '0;
        else if (res_capture) res_q <= formatted;
    end

    assign res_data = res_q;
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          mem_valid,
    input logic          mem_rd,
    input logic          res_we,
    input logic          cancel,
    input logic [DW-1:0] res_data
);
    // R2
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && res_we));

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_valid) |=> mem_rd);

    // R3
    capture_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_valid) |=> (res_we && !cancel && !mem_rd));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> !res_we);

    // R10
    cancel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> (res_we && res_data == '0 && !mem_rd));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !res_we && !req_valid) |=> (!mem_rd && !res_we));
endmodule

bind ldfmt_top ldfmt_chk #(.DW(8*LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_valid (mem_valid),
    .mem_rd    (mem_rd),
    .res_we    (res_we),
    .cancel    (cancel),
    .res_data  (res_data)
);

// File: tb/ldfmt_top_test.sv
module ldfmt_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic        sign_ext = 1'b0;
    logic        pred_en = 1'b0;
    logic [1:0]  pred_sel = '0;
    logic [7:0]  pred_old = '0;
    logic [7:0]  pred_new = '0;
    logic [63:0] old_pair = '0;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;
    logic        mem_rd, res_we, cancel;
    logic [63:0] res_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] last_res = '0;

    ldfmt_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .size(size),
        .sign_ext(sign_ext), .pred_en(pred_en), .pred_sel(pred_sel),
        .pred_old(pred_old), .pred_new(pred_new), .old_pair(old_pair),
        .mem_valid(mem_valid), .mem_data(mem_data), .mem_rd(mem_rd),
        .res_we(res_we), .cancel(cancel), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] ref_fmt(input logic [2:0] o, input logic [1:0] s,
                                            input logic sg, input logic [63:0] old,
                                            input logic [63:0] m);
        logic [63:0] v = '0;
        case (o)
            3'd0: case (s)
                2'd0: v = sg ? 64'($signed(m[7:0]))  : 64'(m[7:0]);
                2'd1: v = sg ? 64'($signed(m[15:0])) : 64'(m[15:0]);
                2'd2: v = 64'(m[31:0]);
                default: v = m;
            endcase
            3'd1, 3'd2: for (int i = 0; i < ((o == 3'd1) ? 2 : 4); i++)
                v[16*i +: 16] = sg ? 16'($signed(m[8*i +: 8])) : 16'(m[8*i +: 8]);
            3'd3: v = (old >> 16) | (64'(m[15:0]) << 48);
            default: v = (old >> 8) | (64'(m[7:0]) << 56);
        endcase
        return v;
    endfunction

    function automatic bit ref_go(input logic en, input logic [1:0] sel,
                                  input logic [7:0] po, input logic [7:0] pn);
        bit p = sel[1] ? pn[0] : po[0];
        return !en || (p != sel[0]);
    endfunction

    // one comparison of every output against the model for the current cycle
    task automatic cyc(input bit e_rd, input bit e_we, input bit e_can,
                       input logic [63:0] e_data, input string tag);
        checks++;
        if (mem_rd !== e_rd || res_we !== e_we || cancel !== e_can || res_data !== e_data) begin
            failures++;
            $display("FAIL %s: rd/we/cancel=%b%b%b data=%h expected %b%b%b data=%h",
                     tag, mem_rd, res_we, cancel, res_data, e_rd, e_we, e_can, e_data);
        end
    endtask

    task automatic run_load(input logic [2:0] o, input logic [1:0] s, input logic sg,
                            input logic pen, input logic [1:0] psel,
                            input logic [7:0] po, input logic [7:0] pn,
                            input logic [63:0] old, input logic [63:0] m,
                            input int lat, input bit poke, input string tag);
        logic [63:0] exp_v;
        @(negedge clk);
        req_valid = 1'b1; op = o; size = s; sign_ext = sg; pred_en = pen;
        pred_sel = psel; pred_old = po; pred_new = pn; old_pair = old;
        @(negedge clk);
        req_valid = poke;
        if (poke) begin
            op = 3'd4 - o; size = ~s; sign_ext = ~sg; old_pair = ~old; pred_en = 1'b0;
        end
        if (!ref_go(pen, psel, po, pn)) begin
            cyc(1'b0, 1'b1, 1'b1, 64'h0, {tag, "/R10"});
            last_res = '0;
            req_valid = 1'b0;
            @(negedge clk);
            cyc(1'b0, 1'b0, 1'b0, last_res, "R10 idle");
            return;
        end
        exp_v = ref_fmt(o, s, sg, old, m);
        cyc(1'b1, 1'b0, 1'b0, last_res, "R2 fetch");
        for (int i = 0; i < lat; i++) begin
            mem_data = ~m;
            @(negedge clk);
            cyc(1'b1, 1'b0, 1'b0, last_res, "R2 hold");
        end
        mem_valid = 1'b1; mem_data = m;
        @(negedge clk);
        mem_valid = 1'b0; mem_data = 64'hDEAD_BEEF_0BAD_F00D; req_valid = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, exp_v, tag);
        last_res = exp_v;
        @(negedge clk);
        cyc(1'b0, 1'b0, 1'b0, last_res, "R3 retire");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 64'h0, "R1 reset");

        // R11: data valid while idle has no effect
        mem_valid = 1'b1; mem_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        mem_valid = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 64'h0, "R11 stray valid");

        // R4 plain loads
        run_load(3'd0, 2'd0, 1'b1, 0, 2'd0, 0, 0, 0, 64'h1122_3344_5566_7788 | 64'h80, 0, 0, "R4 byte signed");
        run_load(3'd0, 2'd0, 1'b0, 0, 2'd0, 0, 0, 0, 64'h0000_0000_0000_00F5, 1, 0, "R4 byte unsigned");
        run_load(3'd0, 2'd0, 1'b1, 0, 2'd0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF35, 0, 0, "R4 byte pos");
        run_load(3'd0, 2'd1, 1'b1, 0, 2'd0, 0, 0, 0, 64'hAAAA_AAAA_AAAA_9234, 2, 0, "R4 half signed");
        run_load(3'd0, 2'd1, 1'b0, 0, 2'd0, 0, 0, 0, 64'hAAAA_AAAA_AAAA_9234, 0, 0, "R4 half unsigned");
        run_load(3'd0, 2'd2, 1'b1, 0, 2'd0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 0, 0, "R4 word");
        run_load(3'd0, 2'd3, 1'b1, 0, 2'd0, 0, 0, 0, 64'hFEDC_BA98_7654_3210, 3, 0, "R4 double");

        // R5 / R6 expansion
        run_load(3'd1, 2'd0, 1'b1, 0, 2'd0, 0, 0, 0, 64'h5555_5555_5555_7F81, 0, 0, "R5 exp2 signed");
        run_load(3'd1, 2'd0, 1'b0, 0, 2'd0, 0, 0, 0, 64'h5555_5555_5555_7F81, 1, 0, "R5 exp2 unsigned");
        run_load(3'd2, 2'd0, 1'b1, 0, 2'd0, 0, 0, 0, 64'h9999_9999_C301_80FF, 0, 0, "R6 exp4 signed");
        run_load(3'd2, 2'd0, 1'b0, 0, 2'd0, 0, 0, 0, 64'h9999_9999_C301_80FF, 2, 0, "R6 exp4 unsigned");

        // R7 / R8 alignment, with old pair changed mid-fetch (R11 poke)
        run_load(3'd3, 2'd0, 1'b0, 0, 2'd0, 0, 0, 64'h0102_0304_0506_0708, 64'h0000_0000_0000_BEEF, 1, 1, "R7 align half");
        run_load(3'd4, 2'd0, 1'b1, 0, 2'd0, 0, 0, 64'h0102_0304_0506_0708, 64'h0000_0000_0000_00C9, 2, 1, "R8 align byte");
        run_load(3'd0, 2'd0, 1'b1, 0, 2'd0, 0, 0, 0, 64'h0000_0000_0000_0080, 1, 1, "R11 poke plain");

        // R9 / R10 predicate variants, upper predicate bits as noise
        run_load(3'd0, 2'd3, 1'b0, 1, 2'd0, 8'hFE, 8'hFF, 0, 64'hAAAA_0000_5555_1111, 0, 0, "R9 old true cancel");
        run_load(3'd0, 2'd3, 1'b0, 1, 2'd0, 8'h01, 8'h00, 0, 64'hAAAA_0000_5555_1111, 0, 0, "R9 old true go");
        run_load(3'd0, 2'd3, 1'b0, 1, 2'd1, 8'hFF, 8'h00, 0, 64'h1234_0000_5555_1111, 0, 0, "R9 old false cancel");
        run_load(3'd0, 2'd3, 1'b0, 1, 2'd1, 8'hFE, 8'h01, 0, 64'h1234_0000_5555_2222, 1, 0, "R9 old false go");
        run_load(3'd1, 2'd0, 1'b1, 1, 2'd2, 8'h01, 8'hFE, 0, 64'h0000_0000_0000_8001, 0, 0, "R9 new true cancel");
        run_load(3'd1, 2'd0, 1'b1, 1, 2'd2, 8'h00, 8'h81, 0, 64'h0000_0000_0000_8001, 0, 0, "R9 new true go");
        run_load(3'd4, 2'd0, 1'b0, 1, 2'd3, 8'h00, 8'h01, 64'h1111_2222_3333_4444, 64'hEE, 0, 0, "R9 new false cancel");
        run_load(3'd4, 2'd0, 1'b0, 1, 2'd3, 8'h01, 8'hF0, 64'h1111_2222_3333_4444, 64'hEE, 0, 0, "R9 new false go");
        run_load(3'd2, 2'd0, 1'b0, 1, 2'd0, 8'h00, 8'h00, 0, 64'h0102_0304, 0, 1, "R10 cancel with poke");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule